// File: doc/BRIEF.md
# Motion Stop Command Dispatcher

This block turns stop requests into one-cycle stop strobes for a set of motion coordinate groups, eight by default. Requests arrive from two sides. A front panel supplies an abort line, a hold line and four active-low selector lines that name one group. A host supplies a stream of single-byte commands. The block answers each accepted request with an abort, hold, quit (stop at the end of the current move) or kill strobe. The strobe goes to one group, to every group, or to one motor.

The host also loads two target registers: the addressed group and the addressed motor. A plain letter command acts only on the current target. A control character acts on every group or every motor. A motor-to-group map is supplied as an input. The block uses it to refuse a kill issued from inside a motion program when the target motor belongs to the group running that program. A refused kill raises a reject strobe and no kill.

Groups are numbered 1 to 8 and appear on bits 0 to 7 of the group vectors. Motors are numbered 0 to 7 and appear on the bit of the same number of the kill vector. Every result is registered and appears one clock after the request is sampled.

Top module: `halt_dispatch`

## Requirements
- R1: During synchronous active-low reset and in the cycle after it, every output is zero. After reset the addressed group is 1 and the addressed motor is 0.
- R2: The panel selector value is the bitwise inverse of `pnl_sel_n`, with bit 0 as the LSB. A value v from 1 to 8 selects group v (output bit v-1). Value 0 and values 9 to 15 select nothing, so panel abort and hold produce no strobe.
- R3: A rising edge on `pnl_abort` gives a one-cycle strobe on `abort_o` for the selected group. A rising edge on `pnl_hold` does the same on `hold_o`. A line held high gives only that one strobe.
- R4: Byte 0x01 strobes `abort_o` for all groups. Byte 0x41 ('A') strobes it for the addressed group only.
- R5: Byte 0x0F strobes `hold_o` for all groups. Byte 0x48 ('H') strobes it for the addressed group only.
- R6: Byte 0x11 strobes `quit_o` for all groups. Byte 0x51 ('Q') strobes it for the addressed group only.
- R7: Byte 0x0B strobes `kill_o` for all motors. Byte 0x4B ('K') strobes it for the addressed motor only.
- R8: A 0x4B byte with `cmd_in_prog` high is refused when the group mapped to the addressed motor equals `cmd_prog_grp`. A refused kill gives a one-cycle `reject_o` strobe and leaves `kill_o` at zero. In every other case, 0x0B included, the kill is accepted.
- R9: Every byte not listed in R4 to R7, and any byte presented while `cmd_valid` is low, produces no output.
- R10: A load of the addressed group takes effect only for values 1 to 8; other values are ignored. A load of the addressed motor takes effect only for values below the motor count. A command in the same cycle as a load uses the previous target.
- R11: Panel and host requests in the same cycle are merged by OR on the group vectors.
- R12: Each strobe appears exactly one clock after the request is sampled and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pnl_abort | input | 1 | Panel abort request line, active high |
| pnl_hold | input | 1 | Panel hold request line, active high |
| pnl_sel_n | input | 4 | Panel group selector, active low, bit 0 is LSB |
| cmd_valid | input | 1 | Host byte present this cycle |
| cmd_byte | input | 8 | Host command byte |
| cmd_in_prog | input | 1 | Byte was issued from inside a motion program |
| cmd_prog_grp | input | 4 | Group (1..8) running the issuing program |
| tgt_grp_we | input | 1 | Load the addressed group |
| tgt_grp_val | input | 4 | New addressed group (1..8) |
| tgt_mtr_we | input | 1 | Load the addressed motor |
| tgt_mtr_val | input | 3 | New addressed motor index |
| mtr_grp_map | input | 32 | Group of each motor, 4 bits per motor, motor 0 lowest |
| abort_o | output | 8 | Per-group abort strobe |
| hold_o | output | 8 | Per-group hold strobe |
| quit_o | output | 8 | Per-group quit strobe |
| kill_o | output | 8 | Per-motor kill strobe |
| reject_o | output | 1 | Refused-kill strobe |

## Verification
Every result of this block is due on the first rising edge after the request is applied. This holds for panel edges, host bytes, refused kills and merged requests alike. The driver changes inputs on the falling edge and queues exactly one expected output set for the next rising edge. The monitor compares that set 1 ns after the rising edge, so each check lands in the cycle of the strobe. A missing or extra strobe in any cycle shows up as a mismatch, and that covers a held panel line that repeats its strobe. The load-collision cases use the same cycle alignment to show that a target load affects only the following command.

// File: rtl/halt_pkg.sv
// Package: shared command codes for the stop dispatcher.
// Assumes host commands are single bytes; all other bytes are no-ops.
package halt_pkg;
    localparam logic [7:0] CMD_ABORT_ALL = 8'h01;
    localparam logic [7:0] CMD_KILL_ALL  = 8'h0B;
    localparam logic [7:0] CMD_HOLD_ALL  = 8'h0F;
    localparam logic [7:0] CMD_QUIT_ALL  = 8'h11;
    localparam logic [7:0] CMD_ABORT_ONE = 8'h41;
    localparam logic [7:0] CMD_HOLD_ONE  = 8'h48;
    localparam logic [7:0] CMD_KILL_ONE  = 8'h4B;
    localparam logic [7:0] CMD_QUIT_ONE  = 8'h51;

    // Decoded host request, one flag per action and reach
    typedef struct packed {
        logic abort_all;
        logic abort_one;
        logic hold_all;
        logic hold_one;
        logic quit_all;
        logic quit_one;
        logic kill_all;
        logic kill_one;
    } host_req_t;
endpackage

// File: rtl/halt_target_regs.sv
// Module: addressed group and addressed motor registers.
// Loads with out-of-range values are dropped so the targets stay legal.
// Assumes groups are numbered from 1 and motors from 0.
module halt_target_regs #(
    parameter int NG = 8,
    parameter int NM = 8,
    localparam int GW = $clog2(NG + 1),
    localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_we,
    input  logic [GW-1:0] grp_val,
    input  logic          mtr_we,
    input  logic [MW-1:0] mtr_val,
    output logic [GW-1:0] grp_q,
    output logic [MW-1:0] mtr_q
);
    logic grp_ok;
    logic mtr_ok;

    // Range checks on the incoming load values
    assign grp_ok = (grp_val >= GW'(1)) && (grp_val <= GW'(NG));
    assign mtr_ok = ({1'b0, mtr_val} < (MW+1)'(NM));

    // Hold or update the addressed group
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_q <= GW'(1);
        else if (grp_we && grp_ok)
            grp_q <= grp_val;
    end

    // Hold or update the addressed motor
    always_ff @(posedge clk) begin
        if (!rst_n)
            mtr_q <= '0;
        else if (mtr_we && mtr_ok)
            mtr_q <= mtr_val;
    end

    p_grp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_q >= GW'(1)) && (grp_q <= GW'(NG)))
        else $error("addressed group out of range");

    p_bad_load_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_we && !((grp_val >= GW'(1)) && (grp_val <= GW'(NG)))) |=> $stable(grp_q))
        else $error("illegal group load changed target");
endmodule

// File: rtl/halt_panel_front.sv
// Module: panel request front end. Detects rising edges on the abort and
// hold lines and steers a one-cycle strobe to the group named by the
// inverted selector. Assumes the panel lines are already synchronous.
module halt_panel_front #(
    parameter int NG = 8,
    localparam int GW = $clog2(NG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort_line,
    input  logic          hold_line,
    input  logic [GW-1:0] sel_n,
    output logic [NG-1:0] abort_vec,
    output logic [NG-1:0] hold_vec
);
    logic [GW-1:0] sel;
    logic [NG-1:0] grp_dec;
    logic          abort_prev;
    logic          hold_prev;

    assign sel = ~sel_n;

    // One-hot decode of the selector; 0 and values above NG select nothing
    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign grp_dec[g] = (sel == GW'(g + 1));
    end

    // Remember the previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_prev <= 1'b0;
            hold_prev  <= 1'b0;
        end else begin
            abort_prev <= abort_line;
            hold_prev  <= hold_line;
        end
    end

    // Register the steered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_vec <= '0;
            hold_vec  <= '0;
        end else begin
            abort_vec <= (abort_line && !abort_prev) ? grp_dec : '0;
            hold_vec  <= (hold_line  && !hold_prev)  ? grp_dec : '0;
        end
    end

    p_one_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(abort_vec) && $onehot0(hold_vec))
        else $error("panel strobe reached several groups");

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort_vec) |=> !(|abort_vec))
        else $error("panel abort strobe longer than a cycle");

    p_hold_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_vec) |=> !(|hold_vec))
        else $error("panel hold strobe longer than a cycle");
endmodule

// File: rtl/halt_host_decode.sv
// Module: host byte decoder. Maps each command byte to a registered
// strobe on the group or motor vectors. It refuses an in-program kill
// whose target motor sits in the issuing group. Assumes one byte per
// valid cycle and a motor map of GW bits per motor.
module halt_host_decode
    import halt_pkg::*;
#(
    parameter int NG = 8,
    parameter int NM = 8,
    localparam int GW = $clog2(NG + 1),
    localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             cmd_in_prog,
    input  logic [GW-1:0]    cmd_prog_grp,
    input  logic [GW-1:0]    tgt_grp,
    input  logic [MW-1:0]    tgt_mtr,
    input  logic [NM*GW-1:0] mtr_grp_map,
    output logic [NG-1:0]    abort_vec,
    output logic [NG-1:0]    hold_vec,
    output logic [NG-1:0]    quit_vec,
    output logic [NM-1:0]    kill_vec,
    output logic             reject
);
    host_req_t     req;
    logic [NG-1:0] tgt_grp_vec;
    logic [NM-1:0] tgt_mtr_vec;
    logic [GW-1:0] tgt_mtr_grp;
    logic          kill_refused;

    // Translate the byte into a request flag set
    always_comb begin
        req = '0;
        if (cmd_valid) begin
            case (cmd_byte)
                CMD_ABORT_ALL: req.abort_all = 1'b1;
                CMD_ABORT_ONE: req.abort_one = 1'b1;
                CMD_HOLD_ALL:  req.hold_all  = 1'b1;
                CMD_HOLD_ONE:  req.hold_one  = 1'b1;
                CMD_QUIT_ALL:  req.quit_all  = 1'b1;
                CMD_QUIT_ONE:  req.quit_one  = 1'b1;
                CMD_KILL_ALL:  req.kill_all  = 1'b1;
                CMD_KILL_ONE:  req.kill_one  = 1'b1;
                default:       req = '0;
            endcase
        end
    end

    // One-hot of the addressed group
    for (genvar g = 0; g < NG; g++) begin : g_tgt
        assign tgt_grp_vec[g] = (tgt_grp == GW'(g + 1));
    end

    // One-hot of the addressed motor
    always_comb begin
        tgt_mtr_vec = '0;
        tgt_mtr_vec[tgt_mtr] = 1'b1;
    end

    // Group of the addressed motor and the in-program refusal test
    assign tgt_mtr_grp  = mtr_grp_map[tgt_mtr*GW +: GW];
    assign kill_refused = req.kill_one && cmd_in_prog && (tgt_mtr_grp == cmd_prog_grp);

    // Register the strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_vec <= '0;
            hold_vec  <= '0;
            quit_vec  <= '0;
            kill_vec  <= '0;
            reject    <= 1'b0;
        end else begin
            abort_vec <= req.abort_all ? '1 : (req.abort_one ? tgt_grp_vec : '0);
            hold_vec  <= req.hold_all  ? '1 : (req.hold_one  ? tgt_grp_vec : '0);
            quit_vec  <= req.quit_all  ? '1 : (req.quit_one  ? tgt_grp_vec : '0);
            kill_vec  <= req.kill_all  ? '1 :
                         ((req.kill_one && !kill_refused) ? tgt_mtr_vec : '0);
            reject    <= kill_refused;
        end
    end

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (abort_vec == '0 && hold_vec == '0 && quit_vec == '0
                        && kill_vec == '0 && !reject))
        else $error("output without a valid byte");

    p_reject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(cmd_valid && cmd_byte == CMD_KILL_ONE && cmd_in_prog))
        else $error("reject without an in-program kill");

    p_reject_no_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (kill_vec == '0))
        else $error("refused kill still strobed");
endmodule

// File: rtl/halt_dispatch.sv
// Module: stop command dispatcher top. Merges panel and host stop
// requests into per-group abort, hold and quit strobes and per-motor
// kill strobes, all one cycle after the request.
// Assumes all inputs are synchronous to clk.
module halt_dispatch #(
    parameter int NG = 8,
    parameter int NM = 8,
    localparam int GW = $clog2(NG + 1),
    localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pnl_abort,
    input  logic             pnl_hold,
    input  logic [GW-1:0]    pnl_sel_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             cmd_in_prog,
    input  logic [GW-1:0]    cmd_prog_grp,
    input  logic             tgt_grp_we,
    input  logic [GW-1:0]    tgt_grp_val,
    input  logic             tgt_mtr_we,
    input  logic [MW-1:0]    tgt_mtr_val,
    input  logic [NM*GW-1:0] mtr_grp_map,
    output logic [NG-1:0]    abort_o,
    output logic [NG-1:0]    hold_o,
    output logic [NG-1:0]    quit_o,
    output logic [NM-1:0]    kill_o,
    output logic             reject_o
);
    logic [GW-1:0] tgt_grp;
    logic [MW-1:0] tgt_mtr;
    logic [NG-1:0] pnl_abort_vec, pnl_hold_vec;
    logic [NG-1:0] host_abort_vec, host_hold_vec, host_quit_vec;

    halt_target_regs #(.NG(NG), .NM(NM)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .grp_we(tgt_grp_we), .grp_val(tgt_grp_val),
        .mtr_we(tgt_mtr_we), .mtr_val(tgt_mtr_val),
        .grp_q(tgt_grp), .mtr_q(tgt_mtr)
    );

    halt_panel_front #(.NG(NG)) u_pnl (
        .clk(clk), .rst_n(rst_n),
        .abort_line(pnl_abort), .hold_line(pnl_hold), .sel_n(pnl_sel_n),
        .abort_vec(pnl_abort_vec), .hold_vec(pnl_hold_vec)
    );

    halt_host_decode #(.NG(NG), .NM(NM)) u_host (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_in_prog(cmd_in_prog), .cmd_prog_grp(cmd_prog_grp),
        .tgt_grp(tgt_grp), .tgt_mtr(tgt_mtr), .mtr_grp_map(mtr_grp_map),
        .abort_vec(host_abort_vec), .hold_vec(host_hold_vec),
        .quit_vec(host_quit_vec), .kill_vec(kill_o), .reject(reject_o)
    );

    // Merge the two request sources
    assign abort_o = pnl_abort_vec | host_abort_vec;
    assign hold_o  = pnl_hold_vec  | host_hold_vec;
    assign quit_o  = host_quit_vec;

    p_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pnl_abort_vec & abort_o) == pnl_abort_vec) && ((host_abort_vec & abort_o) == host_abort_vec))
        else $error("a merged abort source was lost");
endmodule

// File: tb/halt_dispatch_test.sv
// Bench: scoreboard for halt_dispatch. The driver queues the expected
// outputs for each rising edge and the monitor compares them 1 ns after it.
module halt_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pnl_abort = 1'b0, pnl_hold = 1'b0;
    logic [3:0]  pnl_sel_n = 4'hF;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_in_prog = 1'b0;
    logic [3:0]  cmd_prog_grp = 4'd0;
    logic        tgt_grp_we = 1'b0, tgt_mtr_we = 1'b0;
    logic [3:0]  tgt_grp_val = 4'd0;
    logic [2:0]  tgt_mtr_val = 3'd0;
    logic [31:0] mtr_grp_map;
    logic [7:0]  abort_o, hold_o, quit_o, kill_o;
    logic        reject_o;

    typedef struct packed {
        logic [7:0] ab, ho, qu, ki;
        logic       rj;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    halt_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .pnl_abort(pnl_abort), .pnl_hold(pnl_hold), .pnl_sel_n(pnl_sel_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_in_prog(cmd_in_prog), .cmd_prog_grp(cmd_prog_grp),
        .tgt_grp_we(tgt_grp_we), .tgt_grp_val(tgt_grp_val),
        .tgt_mtr_we(tgt_mtr_we), .tgt_mtr_val(tgt_mtr_val),
        .mtr_grp_map(mtr_grp_map),
        .abort_o(abort_o), .hold_o(hold_o), .quit_o(quit_o),
        .kill_o(kill_o), .reject_o(reject_o)
    );

    // Motor i belongs to group i/2 + 1
    initial begin
        for (int i = 0; i < 8; i++) mtr_grp_map[i*4 +: 4] = 4'(i/2 + 1);
    end

    // Queue the expectation for the coming edge, then clear one-shot inputs
    task automatic tick(input logic [7:0] ab, ho, qu, ki, input logic rj, input string tag);
        exp_t e;
        e.ab = ab; e.ho = ho; e.qu = qu; e.ki = ki; e.rj = rj;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0; tgt_grp_we = 1'b0; tgt_mtr_we = 1'b0; cmd_in_prog = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1; cmd_byte = b;
    endtask

    // Monitor: compare outputs just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {abort_o, hold_o, quit_o, kill_o, reject_o};
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got ab=%h ho=%h qu=%h ki=%h rj=%b, expected ab=%h ho=%h qu=%h ki=%h rj=%b",
                             t, a.ab, a.ho, a.qu, a.ki, a.rj, e.ab, e.ho, e.qu, e.ki, e.rj);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset clears everything
        tick(0, 0, 0, 0, 0, "R1 reset");
        tick(0, 0, 0, 0, 0, "R1 reset");
        rst_n = 1'b1;
        tick(0, 0, 0, 0, 0, "R1 idle after reset");
        send(8'h41); tick(8'h01, 0, 0, 0, 0, "R1 R4 addressed group 1 after reset");
        send(8'h4B); tick(0, 0, 0, 8'h01, 0, "R1 R7 addressed motor 0 after reset");

        // R2 R3: panel abort to group 3, held line gives one strobe
        pnl_sel_n = ~4'd3; pnl_abort = 1'b1; tick(8'h04, 0, 0, 0, 0, "R2 R3 panel abort grp3");
        tick(0, 0, 0, 0, 0, "R3 held abort no repeat");
        pnl_abort = 1'b0; tick(0, 0, 0, 0, 0, "R3 release");
        pnl_sel_n = 4'hF; pnl_abort = 1'b1; tick(0, 0, 0, 0, 0, "R2 selector 0 disabled");
        pnl_abort = 1'b0; tick(0, 0, 0, 0, 0, "R2 release");
        pnl_sel_n = ~4'd9; pnl_hold = 1'b1; tick(0, 0, 0, 0, 0, "R2 selector 9 disabled");
        pnl_hold = 1'b0; tick(0, 0, 0, 0, 0, "R2 release");
        pnl_sel_n = ~4'd8; pnl_hold = 1'b1; tick(0, 8'h80, 0, 0, 0, "R3 panel hold grp8");
        tick(0, 0, 0, 0, 0, "R3 held hold no repeat");
        pnl_hold = 1'b0; tick(0, 0, 0, 0, 0, "R3 release");

        // R4..R7: broadcast commands
        send(8'h01); tick(8'hFF, 0, 0, 0, 0, "R4 abort all");
        send(8'h0F); tick(0, 8'hFF, 0, 0, 0, "R5 hold all");
        send(8'h11); tick(0, 0, 8'hFF, 0, 0, "R6 quit all");
        send(8'h0B); tick(0, 0, 0, 8'hFF, 0, "R7 kill all");

        // R10: load collides with command, old target used
        tgt_grp_we = 1'b1; tgt_grp_val = 4'd5; send(8'h48);
        tick(0, 8'h01, 0, 0, 0, "R10 load same cycle uses old group");
        send(8'h48); tick(0, 8'h10, 0, 0, 0, "R5 hold addressed grp5");
        send(8'h51); tick(0, 0, 8'h10, 0, 0, "R6 quit addressed grp5");
        tgt_grp_we = 1'b1; tgt_grp_val = 4'd0; tick(0, 0, 0, 0, 0, "R10 load 0");
        tgt_grp_we = 1'b1; tgt_grp_val = 4'd9; tick(0, 0, 0, 0, 0, "R10 load 9");
        send(8'h41); tick(8'h10, 0, 0, 0, 0, "R10 illegal loads ignored");

        // R8: in-program kill refusal (motor 5 is in group 3)
        tgt_mtr_we = 1'b1; tgt_mtr_val = 3'd5; tick(0, 0, 0, 0, 0, "R10 motor load");
        send(8'h4B); cmd_in_prog = 1'b1; cmd_prog_grp = 4'd3;
        tick(0, 0, 0, 0, 1, "R8 refused kill");
        send(8'h4B); cmd_in_prog = 1'b1; cmd_prog_grp = 4'd2;
        tick(0, 0, 0, 8'h20, 0, "R8 other group kill accepted");
        send(8'h4B); cmd_in_prog = 1'b0; cmd_prog_grp = 4'd3;
        tick(0, 0, 0, 8'h20, 0, "R7 R8 host kill accepted");
        send(8'h0B); cmd_in_prog = 1'b1; cmd_prog_grp = 4'd3;
        tick(0, 0, 0, 8'hFF, 0, "R8 kill-all not refused");

        // R9: ignored bytes and invalid cycles
        send(8'h61); tick(0, 0, 0, 0, 0, "R9 lower-case a");
        send(8'h00); tick(0, 0, 0, 0, 0, "R9 byte 00");
        send(8'h42); tick(0, 0, 0, 0, 0, "R9 byte 42");
        send(8'hFF); tick(0, 0, 0, 0, 0, "R9 byte FF");
        cmd_byte = 8'h41; tick(0, 0, 0, 0, 0, "R9 valid low");

        // R11 R12: panel grp2 and host grp5 in the same cycle, then gone
        pnl_sel_n = ~4'd2; pnl_abort = 1'b1; send(8'h41);
        tick(8'h12, 0, 0, 0, 0, "R11 merged abort");
        pnl_abort = 1'b0; tick(0, 0, 0, 0, 0, "R12 one-cycle strobe");

        @(posedge clk); #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule